// File: doc/BRIEF.md
# Time-Slot Serial Port with Sample Repetition

This block is the serial side of a single companded voice channel on a time-division bus. A serial clock and a one-clock frame sync divide the bus into frames of eight-bit slots. The port drives one outgoing byte, most significant bit first, in a slot chosen by a slot index. In the same slot it takes in one incoming byte. Between slots its data output is released so that other devices can drive the shared line.

In repeat mode, each outgoing byte occupies its slot in two consecutive frames. Incoming bytes are assumed to arrive twice in the same way. A frame parity bit marks each frame as a "first" frame or a "repeat" frame. New words are taken from the core only in first frames, and captured words go back to the core only in first frames. A configuration-busy input releases the output driver at once, while the port keeps counting bit positions.

Top module: `slot_serial_port`

## Requirements
- R1: After a synchronous active-high reset, `sdo_oe`, `sdo`, `tx_taken`, `rx_valid` and `rx_data` are all 0. They stay 0 until the first frame sync is seen.
- R2: The frame sync is sampled high at a rising edge. The bit period that starts at that edge is position 0. Slot n covers positions 8n to 8n+7. `sdo_oe` is high in exactly those eight periods for n = `slot`.
- R3: In position 8n+k of the active slot, `sdo` carries bit 7-k of the current word, so the MSB goes first. `sdo` is 0 whenever `sdo_oe` is 0.
- R4: In a first frame, the port takes `tx_data` at the rising edge that opens the slot. `tx_taken` is high for that one period. With repeat mode off, every frame is a first frame.
- R5: With repeat mode on, frames alternate between first and repeat. A repeat frame resends the previous word unchanged and does not assert `tx_taken`. The first frame after reset, and the first frame after repeat mode is switched on, is a first frame.
- R6: `sdi` is sampled on the falling edge of each of the eight slot periods and shifted in MSB first. The byte appears on `rx_data` with `rx_valid` high for the one period that follows the slot's last bit.
- R7: With repeat mode on, `rx_valid` is asserted only in first frames. Input in a repeat frame is ignored, and `rx_data` keeps its value.
- R8: While `cfg_busy` is high, `sdo_oe` and `sdo` are forced to 0 in the same cycle. Bit counting, word loading and input capture go on unchanged.
- R9: `rep_en` is sampled only at a frame sync. A change between syncs has no effect until the next sync.
- R10: Reset in the middle of a slot stops the output and discards the partly captured byte. No slot activity occurs until a new frame sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | One-clock frame sync, marks position 0 |
| rep_en | input | 1 | Repeat mode enable, sampled at frame sync |
| cfg_busy | input | 1 | Configuration update in progress; releases output |
| slot | input | $clog2(SLOTS) | Time slot index; changed only between frames |
| tx_data | input | 8 | Word from the core to send |
| tx_taken | output | 1 | Pulse: `tx_data` was taken at the last rising edge |
| rx_data | output | 8 | Captured byte toward the core |
| rx_valid | output | 1 | One-period pulse: `rx_data` holds a new byte |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (0 when not driven) |
| sdo_oe | output | 1 | Output enable for the external tri-state pad |

## Verification
The port is run with repeat mode off, in slot 0 and in the last slot. These runs separate position counting from slot decoding, and the last slot also checks the end-of-frame edge. Repeat-mode runs with a fresh random word and random input bits on every clock show whether repeat frames resend the old word and ignore new input. Further runs glitch `rep_en` between syncs, pulse `cfg_busy` at random, use short frames with early syncs, and reset in the middle of a slot. These separate sync-time sampling, the immediate output release and the dropping of a partly captured word.

// File: rtl/slot_serial_port.sv
module slot_serial_port #(
  parameter int SLOTS = 32,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fsync,
  input  logic          rep_en,
  input  logic          cfg_busy,
  input  logic [SW-1:0] slot,
  input  logic [7:0]    tx_data,
  output logic          tx_taken,
  output logic [7:0]    rx_data,
  output logic          rx_valid,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe
);
  localparam int PW = $clog2(SLOTS * 8);
  localparam logic [PW-1:0] LAST = PW'(SLOTS * 8 - 1);

  logic [PW-1:0] pos;
  logic          act, rep_q, first_q, oe_q, sdo_q;
  logic [7:0]    txw, rxsh;

  logic [PW-1:0] pos_n;
  logic          act_n, first_n, hit_n, load_n, hit_cur;
  logic [2:0]    idx_n;

  assign pos_n   = fsync ? '0 : pos + 1'b1;
  assign act_n   = fsync | (act & (pos != LAST));
  assign first_n = fsync ? (~rep_en | ~rep_q | ~first_q) : first_q;
  assign hit_n   = act_n && (pos_n[PW-1:3] == slot);
  assign idx_n   = pos_n[2:0];
  assign load_n  = hit_n && (idx_n == 3'd0) && first_n;
  assign hit_cur = act && (pos[PW-1:3] == slot);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos      <= '0;
      act      <= 1'b0;
      rep_q    <= 1'b0;
      first_q  <= 1'b0;
      oe_q     <= 1'b0;
      sdo_q    <= 1'b0;
      txw      <= '0;
      tx_taken <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      pos      <= pos_n;
      act      <= act_n;
      first_q  <= first_n;
      if (fsync) rep_q <= rep_en;
      oe_q     <= hit_n;
      tx_taken <= load_n;
      if (load_n) txw <= tx_data;
      sdo_q    <= hit_n ? (load_n ? tx_data[7] : txw[3'd7 - idx_n]) : 1'b0;
      rx_valid <= hit_cur && (pos[2:0] == 3'd7) && first_q;
      if (hit_cur && (pos[2:0] == 3'd7) && first_q) rx_data <= rxsh;
    end
  end

  always_ff @(negedge clk) begin
    if (hit_cur) rxsh <= {rxsh[6:0], sdi};
  end

  assign sdo_oe = oe_q & ~cfg_busy;
  assign sdo    = sdo_q & sdo_oe;

  // R2
  win_start_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(oe_q) && $stable(slot)) |-> (pos[2:0] == 3'd0));

  // R2
  win_len_chk: assert property (@(posedge clk) disable iff (rst)
    (oe_q && (pos[2:0] != 3'd0) && $stable(slot)) |-> $past(oe_q));

  // R6
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R5
  reload_skip_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(oe_q) && !tx_taken) |-> rep_q);
endmodule

// File: tb/slot_serial_port_tb_top.sv
module slot_serial_port_tb_top;
  localparam int SLOTS = 32;
  localparam int SW = $clog2(SLOTS);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst, fsync, rep_en, cfg_busy, sdi;
  logic [SW-1:0] slot;
  logic [7:0]    tx_data, rx_data;
  logic          tx_taken, rx_valid, sdo, sdo_oe;

  slot_serial_port #(.SLOTS(SLOTS)) dut_i (
    .clk(clk), .rst(rst), .fsync(fsync), .rep_en(rep_en), .cfg_busy(cfg_busy),
    .slot(slot), .tx_data(tx_data), .tx_taken(tx_taken), .rx_data(rx_data),
    .rx_valid(rx_valid), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  int n_chk = 0, n_fail = 0, n_tk = 0, n_rv = 0;
  int m_pos = -1, cur_word = 0, rx_word = 0, e_rd = 0;
  bit m_first = 0, m_rep = 0, e_oe = 0, e_bit = 0, e_taken = 0, e_rv = 0;

  task automatic chk(string req, int a, int e);
    n_chk++;
    if (a != e) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, a, e, $time);
    end
  endtask

  task automatic model_edge();
    bit in_slot;
    if (rst) begin
      m_pos = -1; m_first = 0; m_rep = 0;
      e_oe = 0; e_bit = 0; e_taken = 0; e_rv = 0; e_rd = 0;
      return;
    end
    e_rv = (m_pos >= 0) && (m_pos / 8 == int'(slot)) && (m_pos % 8 == 7) && m_first;
    if (e_rv) e_rd = rx_word;
    if (fsync) begin
      m_pos = 0;
      m_first = (!rep_en || !m_rep) ? 1'b1 : !m_first;
      m_rep = rep_en;
    end else if (m_pos >= 0) begin
      m_pos++;
      if (m_pos == SLOTS * 8) m_pos = -1;
    end
    in_slot = (m_pos >= 0) && (m_pos / 8 == int'(slot));
    e_taken = in_slot && (m_pos % 8 == 0) && m_first;
    if (e_taken) cur_word = int'(tx_data);
    e_oe = in_slot;
    e_bit = in_slot ? bit'((cur_word >> (7 - m_pos % 8)) & 1) : 1'b0;
  endtask

  task automatic tick(bit fs, bit rs, bit rp, bit busy_rand);
    bit oe_exp;
    fsync = fs; rst = rs; rep_en = rp;
    tx_data = 8'($urandom);
    sdi = 1'($urandom);
    cfg_busy = busy_rand ? ($urandom % 3 == 0) : 1'b0;
    if ((m_pos >= 0) && (m_pos / 8 == int'(slot))) rx_word = ((rx_word << 1) | int'(sdi)) & 255;
    #2;
    oe_exp = e_oe && !cfg_busy;
    chk("R2 R8 sdo_oe", int'(sdo_oe), int'(oe_exp));
    chk("R3 R5 sdo", int'(sdo), int'(e_bit & oe_exp));
    chk("R4 R5 tx_taken", int'(tx_taken), int'(e_taken));
    chk("R6 R7 rx_valid", int'(rx_valid), int'(e_rv));
    chk("R6 R7 rx_data", int'(rx_data), e_rd);
    if (tx_taken) n_tk++;
    if (rx_valid) n_rv++;
    @(posedge clk);
    model_edge();
    #1;
  endtask

  task automatic frames(int n, int len, bit rp, bit busy, int glitch_at);
    for (int f = 0; f < n; f++)
      for (int c = 0; c < len; c++)
        tick(c == 0, 1'b0, (c == glitch_at) ? !rp : rp, busy);
  endtask

  task automatic do_reset(int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; fsync = 1'b0; rep_en = 1'b0; cfg_busy = 1'b0; sdi = 1'b0;
    tx_data = '0; slot = '0;
    @(posedge clk);
    model_edge();
    #1;
    do_reset(3);
    idle(20);
    // R1 quiet after reset with no frame sync
    chk("R1 outputs idle", int'(sdo_oe | sdo | tx_taken | rx_valid), 0);
    chk("R1 rx_data", int'(rx_data), 0);

    // R4 plain mode in slot 0: one load per frame
    n_tk = 0;
    frames(3, 256, 1'b0, 1'b0, -1);
    chk("R4 loads in 3 frames", n_tk, 3);

    // R2 R6 last slot, end-of-frame boundary
    do_reset(2); slot = SW'(SLOTS - 1);
    n_rv = 0;
    frames(2, 256, 1'b0, 1'b0, -1);
    idle(4);
    chk("R6 bytes from last slot", n_rv, 2);

    // R5 R7 repeat mode
    do_reset(2); slot = 5;
    n_tk = 0; n_rv = 0;
    frames(4, 256, 1'b1, 1'b0, -1);
    chk("R5 loads in 4 repeat frames", n_tk, 2);
    chk("R7 bytes in 4 repeat frames", n_rv, 2);

    // R8 random configuration-busy pulses
    frames(2, 256, 1'b0, 1'b1, -1);
    frames(2, 256, 1'b1, 1'b1, -1);

    // R9 rep_en glitches between syncs
    do_reset(2); slot = 3;
    n_tk = 0;
    frames(4, 256, 1'b1, 1'b0, 100);
    chk("R9 glitch low ignored", n_tk, 2);
    n_tk = 0;
    frames(2, 256, 1'b0, 1'b0, 100);
    chk("R9 glitch high ignored", n_tk, 2);

    // R10 reset in the middle of slot 1
    slot = 1;
    frames(1, 12, 1'b0, 1'b0, -1);
    n_rv = 0;
    do_reset(2);
    idle(20);
    chk("R10 no output after mid-slot reset", int'(sdo_oe | tx_taken), 0);
    chk("R10 partial byte dropped", n_rv, 0);
    frames(2, 256, 1'b0, 1'b0, -1);

    // R2 R5 short frames with early syncs
    slot = 2;
    frames(3, 40, 1'b1, 1'b0, -1);
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule